// File: doc/BRIEF.md
# CAN Controller Register Front End

This block sits between a memory-mapped AXI4-Lite host port and the protocol engine of a CAN controller. It accepts single-beat reads and writes, decodes an 8-bit byte address into word-spaced register slots, and holds the controller's configuration bytes: operating mode, bit timing, output-clock setup, interrupt enables and the acceptance filter code and mask. Only the low byte of each data word is meaningful.

Writes to the command slot become single-cycle strobes toward the engine: one requests a transmission, the other frees the current receive buffer. Live status, the receive-queue depth and the bytes of the frame window come in from the engine as plain ports and are returned on reads. Receive and other interrupt events are latched as pending bits, cleared by reading the interrupt slot, and combined with the enable byte into one interrupt line.

A reset-mode bit in the mode byte guards the configuration. Timing, clock and filter bytes change only while it is set. Command strobes and writes to the frame window happen only while it is clear. The same addresses from 0x40 serve as filter registers in reset mode and as the frame window in operating mode.

Top module: `can_regif`

## Requirements
- R1: The slot index is address bits [7:2], so bits [1:0] are ignored. Write data is taken from wdata[7:0]. A write has an effect only when wstrb[0] is 1. Read data carries the register byte in rdata[7:0], with all upper bits 0.
- R2: awready and wready are both high exactly when no write response is outstanding. A write is accepted on a clock edge where awvalid, wvalid and awready are all high. bvalid rises in the next cycle and stays high until a cycle with bready high. bresp is always 2'b00.
- R3: arready is high exactly when no read data is outstanding. rvalid rises in the cycle after a read is accepted. It stays high with rdata unchanged until a cycle with rready high. rresp is always 2'b00. Unmapped slots read as 0.
- R4: The mode byte is at 0x00 and can be written in any mode. Its bit 0 is reset mode, and the byte resets to 0x01.
- R5: timing0 (0x18), timing1 (0x1C) and the clock-divider byte (0x7C) change only through writes accepted while mode bit 0 is 1. The clock-divider byte holds bit 7 = extended mode, bit 3 = clock output off and bits 2:0 = output divider. All three read back their value in any mode.
- R6: While mode bit 0 is 1, addresses 0x40..0x4C hold acceptance code bytes 0..3 and 0x50..0x5C hold mask bytes 0..3. Byte k sits at bits [8k+7:8k] of its output. In this mode, 0x60..0x70 read as 0 and ignore writes. While mode bit 0 is 0, 0x40..0x70 form a 13-byte frame window at index (addr-0x40)/4. A read returns byte index of eng_frame_i. A write raises frame_wr_o for one cycle with that index and byte, and leaves the filter bytes unchanged.
- R7: A write accepted at 0x04 while mode bit 0 is 0 raises cmd_tx_req_o for one cycle if data bit 0 is set, and cmd_rx_release_o for one cycle if data bit 2 is set. Both strobes start in the cycle after acceptance. Such writes are ignored while mode bit 0 is 1. The slot reads as 0.
- R8: 0x08 returns eng_status_i, whose bit 2 means the transmit buffer is free. 0x74 returns eng_rx_count_i. Writes to either slot have no effect.
- R9: A 1 on bit k of eng_irq_set_i at a clock edge sets pending bit k. A read of 0x0C returns the pending byte and clears it at acceptance. A set arriving at that same edge survives the clear.
- R10: The enable byte is at 0x10, where bit 0 enables the receive interrupt. After every clock edge, irq_o is 1 exactly when some pending bit has its enable bit set.
- R11: A synchronous active-high reset clears every byte except mode, clears all strobes and valid flags, and drops irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awaddr | input | 8 | Write address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | 32 | Write data |
| s_wstrb | input | 4 | Write byte strobes |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | 8 | Read address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | 32 | Read data |
| s_rresp | output | 2 | Read response |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| eng_status_i | input | 8 | Live status byte from the engine |
| eng_rx_count_i | input | 8 | Frames waiting in the receive queue |
| eng_irq_set_i | input | 8 | Per-bit interrupt event pulses |
| eng_frame_i | input | 104 | Frame window bytes, byte k at [8k+7:8k] |
| mode_o | output | 8 | Mode byte |
| timing0_o | output | 8 | Bit timing byte 0 |
| timing1_o | output | 8 | Bit timing byte 1 |
| clkdiv_o | output | 8 | Clock-divider byte |
| acc_code_o | output | 32 | Acceptance code bytes |
| acc_mask_o | output | 32 | Acceptance mask bytes |
| cmd_tx_req_o | output | 1 | One-cycle transmit request |
| cmd_rx_release_o | output | 1 | One-cycle receive buffer release |
| frame_wr_o | output | 1 | One-cycle frame window write |
| frame_wr_idx_o | output | 4 | Frame window byte index |
| frame_wr_data_o | output | 8 | Frame window byte |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench uses the default parameters: an 8-bit address, a 32-bit data bus, four acceptance bytes and a 13-byte frame window. With these values every slot is reachable, from mode at 0x00 to the clock divider at 0x7C. The last window byte at 0x70 and both halves of the shared 0x40..0x5C range, in reset mode and in operating mode, can each be tested in turn. Because the data bus is wider than a register, the bench can also show that the upper read bits stay at zero and that strobe bits other than bit 0 are ignored.

// File: rtl/can_regif_pkg.sv
package can_regif_pkg;
  // slot indices (byte address / 4)
  localparam int IDX_MODE  = 0;
  localparam int IDX_CMD   = 1;
  localparam int IDX_STAT  = 2;
  localparam int IDX_IRQ   = 3;
  localparam int IDX_IEN   = 4;
  localparam int IDX_TIM0  = 6;
  localparam int IDX_TIM1  = 7;
  localparam int IDX_WIN   = 16;
  localparam int IDX_RXCNT = 29;
  localparam int IDX_CDIV  = 31;

  localparam int MODE_RST_BIT = 0;
  localparam int CMD_TX_BIT   = 0;
  localparam int CMD_REL_BIT  = 2;

  localparam logic [1:0] RESP_OKAY = 2'b00;
endpackage

// File: rtl/can_regif_wch.sv
module can_regif_wch #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 8,
  localparam int IDX_W  = ADDR_W - 2,
  localparam int STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] awaddr,
  input  logic              awvalid,
  input  logic [DATA_W-1:0] wdata,
  input  logic [STRB_W-1:0] wstrb,
  input  logic              wvalid,
  input  logic              bready,
  output logic              awready,
  output logic              wready,
  output logic              bvalid,
  output logic [1:0]        bresp,
  output logic              wr_en,
  output logic [IDX_W-1:0]  wr_idx,
  output logic [REG_W-1:0]  wr_byte
);
  import can_regif_pkg::*;

  logic bvalid_q;
  logic fire;

  assign awready = ~bvalid_q;
  assign wready  = ~bvalid_q;
  assign fire    = awvalid & wvalid & ~bvalid_q;
  assign wr_en   = fire & wstrb[0];
  assign wr_idx  = awaddr[ADDR_W-1:2];
  assign wr_byte = wdata[REG_W-1:0];
  assign bvalid  = bvalid_q;
  assign bresp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (rst)         bvalid_q <= 1'b0;
    else if (fire)   bvalid_q <= 1'b1;
    else if (bready) bvalid_q <= 1'b0;
  end

  logic unused_wr_bits;
  assign unused_wr_bits = ^{awaddr[1:0], wdata[DATA_W-1:REG_W], wstrb[STRB_W-1:1]};
endmodule

// File: rtl/can_regif_rch.sv
module can_regif_rch #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int REG_W  = 8,
  localparam int IDX_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] araddr,
  input  logic              arvalid,
  input  logic              rready,
  input  logic [REG_W-1:0]  rd_byte,
  output logic              arready,
  output logic              rvalid,
  output logic [DATA_W-1:0] rdata,
  output logic [1:0]        rresp,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx
);
  import can_regif_pkg::*;

  logic              rvalid_q;
  logic [DATA_W-1:0] rdata_q;

  assign arready = ~rvalid_q;
  assign rd_en   = arvalid & ~rvalid_q;
  assign rd_idx  = araddr[ADDR_W-1:2];
  assign rvalid  = rvalid_q;
  assign rdata   = rdata_q;
  assign rresp   = RESP_OKAY;

  always_ff @(posedge clk) begin
    if (rst)         rvalid_q <= 1'b0;
    else if (rd_en)  rvalid_q <= 1'b1;
    else if (rready) rvalid_q <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= {{(DATA_W-REG_W){1'b0}}, rd_byte};
  end

  logic unused_rd_bits;
  assign unused_rd_bits = ^araddr[1:0];
endmodule

// File: rtl/can_regif_irq.sv
module can_regif_irq #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         clr_i,
  input  logic         en_we,
  input  logic [W-1:0] en_wdata,
  output logic [W-1:0] pend_o,
  output logic [W-1:0] en_o,
  output logic         irq_o
);
  logic [W-1:0] pend_q, pend_d, en_q, en_d;
  logic         irq_q;

  always_comb begin
    pend_d = (clr_i ? '0 : pend_q) | set_i;
    en_d   = en_we ? en_wdata : en_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
      en_q   <= '0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      en_q   <= en_d;
      irq_q  <= |(pend_d & en_d);
    end
  end

  assign pend_o = pend_q;
  assign en_o   = en_q;
  assign irq_o  = irq_q;
endmodule

// File: rtl/can_regif.sv
module can_regif #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 32,
  parameter int REG_W   = 8,
  parameter int ACC_N   = 4,
  parameter int FRAME_N = 13,
  localparam int STRB_W = DATA_W / 8,
  localparam int FIDX_W = $clog2(FRAME_N)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        s_awaddr,
  input  logic                     s_awvalid,
  output logic                     s_awready,
  input  logic [DATA_W-1:0]        s_wdata,
  input  logic [STRB_W-1:0]        s_wstrb,
  input  logic                     s_wvalid,
  output logic                     s_wready,
  output logic [1:0]               s_bresp,
  output logic                     s_bvalid,
  input  logic                     s_bready,
  input  logic [ADDR_W-1:0]        s_araddr,
  input  logic                     s_arvalid,
  output logic                     s_arready,
  output logic [DATA_W-1:0]        s_rdata,
  output logic [1:0]               s_rresp,
  output logic                     s_rvalid,
  input  logic                     s_rready,
  input  logic [REG_W-1:0]         eng_status_i,
  input  logic [REG_W-1:0]         eng_rx_count_i,
  input  logic [REG_W-1:0]         eng_irq_set_i,
  input  logic [FRAME_N*REG_W-1:0] eng_frame_i,
  output logic [REG_W-1:0]         mode_o,
  output logic [REG_W-1:0]         timing0_o,
  output logic [REG_W-1:0]         timing1_o,
  output logic [REG_W-1:0]         clkdiv_o,
  output logic [ACC_N*REG_W-1:0]   acc_code_o,
  output logic [ACC_N*REG_W-1:0]   acc_mask_o,
  output logic                     cmd_tx_req_o,
  output logic                     cmd_rx_release_o,
  output logic                     frame_wr_o,
  output logic [FIDX_W-1:0]        frame_wr_idx_o,
  output logic [REG_W-1:0]         frame_wr_data_o,
  output logic                     irq_o
);
  import can_regif_pkg::*;

  localparam int IDX_W    = ADDR_W - 2;
  localparam int WIN_LAST = IDX_WIN + FRAME_N - 1;
  localparam int ACC_ALL  = 2 * ACC_N;

  // ---------------- channels ----------------
  logic             wr_en, rd_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [REG_W-1:0] wr_byte, rd_byte;

  can_regif_wch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_wch (
    .clk(clk), .rst(rst),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .wdata(s_wdata), .wstrb(s_wstrb),
    .wvalid(s_wvalid), .bready(s_bready),
    .awready(s_awready), .wready(s_wready), .bvalid(s_bvalid), .bresp(s_bresp),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_byte(wr_byte)
  );

  can_regif_rch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W)) u_rch (
    .clk(clk), .rst(rst),
    .araddr(s_araddr), .arvalid(s_arvalid), .rready(s_rready), .rd_byte(rd_byte),
    .arready(s_arready), .rvalid(s_rvalid), .rdata(s_rdata), .rresp(s_rresp),
    .rd_en(rd_en), .rd_idx(rd_idx)
  );

  // ---------------- decode ----------------
  logic in_reset;
  logic cfg_we, oper_we;
  logic w_win;
  int   wr_off;

  assign in_reset = mode_o[MODE_RST_BIT];
  assign cfg_we   = wr_en & in_reset;
  assign oper_we  = wr_en & ~in_reset;
  assign wr_off   = int'(wr_idx) - IDX_WIN;
  assign w_win    = (int'(wr_idx) >= IDX_WIN) && (int'(wr_idx) <= WIN_LAST);

  // ---------------- mode & configuration ----------------
  logic [REG_W-1:0] mode_q, tim0_q, tim1_q, cdiv_q;

  always_ff @(posedge clk) begin
    if (rst) mode_q <= REG_W'(1);
    else if (wr_en && wr_idx == IDX_W'(IDX_MODE)) mode_q <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tim0_q <= '0;
      tim1_q <= '0;
      cdiv_q <= '0;
    end else if (cfg_we) begin
      if (wr_idx == IDX_W'(IDX_TIM0)) tim0_q <= wr_byte;
      if (wr_idx == IDX_W'(IDX_TIM1)) tim1_q <= wr_byte;
      if (wr_idx == IDX_W'(IDX_CDIV)) cdiv_q <= wr_byte;
    end
  end

  assign mode_o    = mode_q;
  assign timing0_o = tim0_q;
  assign timing1_o = tim1_q;
  assign clkdiv_o  = cdiv_q;

  // ---------------- acceptance bytes ----------------
  for (genvar k = 0; k < ACC_N; k++) begin : g_acc
    logic [REG_W-1:0] code_q, mask_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        code_q <= '0;
        mask_q <= '0;
      end else if (cfg_we) begin
        if (wr_idx == IDX_W'(IDX_WIN + k))         code_q <= wr_byte;
        if (wr_idx == IDX_W'(IDX_WIN + ACC_N + k)) mask_q <= wr_byte;
      end
    end
    assign acc_code_o[k*REG_W +: REG_W] = code_q;
    assign acc_mask_o[k*REG_W +: REG_W] = mask_q;
  end

  // ---------------- command strobes & frame window writes ----------------
  logic             tx_q, rel_q, fwr_q;
  logic [FIDX_W-1:0] fidx_q;
  logic [REG_W-1:0]  fdat_q;
  logic              cmd_hit;

  assign cmd_hit = oper_we && wr_idx == IDX_W'(IDX_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_q  <= 1'b0;
      rel_q <= 1'b0;
      fwr_q <= 1'b0;
    end else begin
      tx_q  <= cmd_hit & wr_byte[CMD_TX_BIT];
      rel_q <= cmd_hit & wr_byte[CMD_REL_BIT];
      fwr_q <= oper_we & w_win;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fidx_q <= '0;
      fdat_q <= '0;
    end else if (oper_we && w_win) begin
      fidx_q <= FIDX_W'(wr_off);
      fdat_q <= wr_byte;
    end
  end

  assign cmd_tx_req_o     = tx_q;
  assign cmd_rx_release_o = rel_q;
  assign frame_wr_o       = fwr_q;
  assign frame_wr_idx_o   = fidx_q;
  assign frame_wr_data_o  = fdat_q;

  // ---------------- interrupts ----------------
  logic [REG_W-1:0] pend, ien;

  can_regif_irq #(.W(REG_W)) u_irq (
    .clk(clk), .rst(rst),
    .set_i(eng_irq_set_i),
    .clr_i(rd_en && rd_idx == IDX_W'(IDX_IRQ)),
    .en_we(wr_en && wr_idx == IDX_W'(IDX_IEN)),
    .en_wdata(wr_byte),
    .pend_o(pend), .en_o(ien), .irq_o(irq_o)
  );

  // ---------------- read mux ----------------
  logic [ACC_ALL*REG_W-1:0] acc_all;
  int                       rd_off;

  assign acc_all = {acc_mask_o, acc_code_o};
  assign rd_off  = int'(rd_idx) - IDX_WIN;

  always_comb begin
    rd_byte = '0;
    case (int'(rd_idx))
      IDX_MODE:  rd_byte = mode_q;
      IDX_STAT:  rd_byte = eng_status_i;
      IDX_IRQ:   rd_byte = pend;
      IDX_IEN:   rd_byte = ien;
      IDX_TIM0:  rd_byte = tim0_q;
      IDX_TIM1:  rd_byte = tim1_q;
      IDX_RXCNT: rd_byte = eng_rx_count_i;
      IDX_CDIV:  rd_byte = cdiv_q;
      default: begin
        if (rd_off >= 0 && rd_off < FRAME_N) begin
          if (!in_reset)            rd_byte = eng_frame_i[rd_off*REG_W +: REG_W];
          else if (rd_off < ACC_ALL) rd_byte = acc_all[rd_off*REG_W +: REG_W];
        end
      end
    endcase
  end
endmodule

// File: rtl/can_regif_chk.sv
module can_regif_chk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              s_awready,
  input logic              s_wready,
  input logic              s_bvalid,
  input logic              s_bready,
  input logic              s_rvalid,
  input logic              s_rready,
  input logic [DATA_W-1:0] s_rdata,
  input logic [REG_W-1:0]  mode_o,
  input logic [REG_W-1:0]  timing0_o,
  input logic [REG_W-1:0]  timing1_o,
  input logic [REG_W-1:0]  clkdiv_o,
  input logic              cmd_tx_req_o,
  input logic              cmd_rx_release_o,
  input logic              frame_wr_o
);
  AST_BVALID_HOLD: assert property (@(posedge clk) disable iff (rst)
    s_bvalid && !s_bready |=> s_bvalid);                                   // R2
  AST_WR_BLOCKED: assert property (@(posedge clk) disable iff (rst)
    s_bvalid |-> !s_awready && !s_wready);                                 // R2
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (rst)
    s_rvalid && !s_rready |=> s_rvalid && $stable(s_rdata));               // R3
  AST_RDATA_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    s_rvalid |-> s_rdata[DATA_W-1:REG_W] == '0);                           // R1
  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    !$past(mode_o[0]) |-> $stable(timing0_o) && $stable(timing1_o) && $stable(clkdiv_o)); // R5
  AST_CMD_OPER_ONLY: assert property (@(posedge clk) disable iff (rst)
    (cmd_tx_req_o || cmd_rx_release_o) |-> !$past(mode_o[0]));             // R7
  AST_TX_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cmd_tx_req_o |=> !cmd_tx_req_o);                                       // R7
  AST_FRAME_OPER_ONLY: assert property (@(posedge clk) disable iff (rst)
    frame_wr_o |-> !$past(mode_o[0]));                                     // R6
endmodule

bind can_regif can_regif_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) u_chk (
  .clk(clk), .rst(rst),
  .s_awready(s_awready), .s_wready(s_wready),
  .s_bvalid(s_bvalid), .s_bready(s_bready),
  .s_rvalid(s_rvalid), .s_rready(s_rready), .s_rdata(s_rdata),
  .mode_o(mode_o), .timing0_o(timing0_o), .timing1_o(timing1_o), .clkdiv_o(clkdiv_o),
  .cmd_tx_req_o(cmd_tx_req_o), .cmd_rx_release_o(cmd_rx_release_o),
  .frame_wr_o(frame_wr_o)
);

// File: tb/tb_can_regif.sv
`timescale 1ns/1ps
module tb_can_regif;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [7:0]   s_awaddr = '0;
  logic         s_awvalid = 1'b0;
  logic         s_awready;
  logic [31:0]  s_wdata = '0;
  logic [3:0]   s_wstrb = '0;
  logic         s_wvalid = 1'b0;
  logic         s_wready;
  logic [1:0]   s_bresp;
  logic         s_bvalid;
  logic         s_bready = 1'b1;
  logic [7:0]   s_araddr = '0;
  logic         s_arvalid = 1'b0;
  logic         s_arready;
  logic [31:0]  s_rdata;
  logic [1:0]   s_rresp;
  logic         s_rvalid;
  logic         s_rready = 1'b1;
  logic [7:0]   eng_status_i = '0;
  logic [7:0]   eng_rx_count_i = '0;
  logic [7:0]   eng_irq_set_i = '0;
  logic [103:0] eng_frame_i;
  logic [7:0]   mode_o, timing0_o, timing1_o, clkdiv_o;
  logic [31:0]  acc_code_o, acc_mask_o;
  logic         cmd_tx_req_o, cmd_rx_release_o, frame_wr_o, irq_o;
  logic [3:0]   frame_wr_idx_o;
  logic [7:0]   frame_wr_data_o;

  initial for (int k = 0; k < 13; k++) eng_frame_i[k*8 +: 8] = 8'hA0 + 8'(k);

  can_regif dut (.*);

  int checks = 0;
  int failures = 0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [7:0]  m_mode, m_t0, m_t1, m_cdiv, m_ien, m_pend;
  logic [7:0]  m_code [4];
  logic [7:0]  m_mask [4];
  logic        m_bvalid, m_rvalid, m_tx, m_rel, m_fwr, m_irq;
  logic [31:0] m_rdata;
  logic [3:0]  m_fidx;
  logic [7:0]  m_fdat;
  bit          run_cmp = 0;

  function automatic logic [7:0] mread(input int i);
    if (i == 0)  return m_mode;
    if (i == 2)  return eng_status_i;
    if (i == 3)  return m_pend;
    if (i == 4)  return m_ien;
    if (i == 6)  return m_t0;
    if (i == 7)  return m_t1;
    if (i == 29) return eng_rx_count_i;
    if (i == 31) return m_cdiv;
    if (i >= 16 && i <= 28) begin
      if (!m_mode[0]) return eng_frame_i[(i-16)*8 +: 8];
      if (i < 20) return m_code[i-16];
      if (i < 24) return m_mask[i-20];
    end
    return 8'h00;
  endfunction

  always @(posedge clk) begin
    bit wf, rf, om;
    int wi, ri;
    logic [7:0] wd, rv, np;
    if (rst) begin
      m_mode = 8'h01; m_t0 = 0; m_t1 = 0; m_cdiv = 0; m_ien = 0; m_pend = 0;
      for (int k = 0; k < 4; k++) begin m_code[k] = 0; m_mask[k] = 0; end
      m_bvalid = 0; m_rvalid = 0; m_rdata = 0; m_tx = 0; m_rel = 0; m_fwr = 0;
      m_irq = 0; m_fidx = 0; m_fdat = 0;
    end else begin
      wf = s_awvalid && s_wvalid && !m_bvalid;
      rf = s_arvalid && !m_rvalid;
      wi = int'(s_awaddr[7:2]);
      ri = int'(s_araddr[7:2]);
      wd = s_wdata[7:0];
      om = m_mode[0];
      rv = rf ? mread(ri) : 8'h00;
      m_tx = 0; m_rel = 0; m_fwr = 0;
      np = (rf && ri == 3) ? 8'h00 : m_pend;
      np = np | eng_irq_set_i;
      if (wf && s_wstrb[0]) begin
        if (wi == 0) m_mode = wd;
        if (wi == 4) m_ien = wd;
        if (om) begin
          if (wi == 6)  m_t0 = wd;
          if (wi == 7)  m_t1 = wd;
          if (wi == 31) m_cdiv = wd;
          if (wi >= 16 && wi < 20) m_code[wi-16] = wd;
          if (wi >= 20 && wi < 24) m_mask[wi-20] = wd;
        end else begin
          if (wi == 1) begin m_tx = wd[0]; m_rel = wd[2]; end
          if (wi >= 16 && wi <= 28) begin m_fwr = 1; m_fidx = 4'(wi-16); m_fdat = wd; end
        end
      end
      m_pend = np;
      m_irq = |(m_pend & m_ien);
      if (m_bvalid && s_bready) m_bvalid = 0;
      if (wf) m_bvalid = 1;
      if (m_rvalid && s_rready) m_rvalid = 0;
      if (rf) begin m_rvalid = 1; m_rdata = {24'h0, rv}; end
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (run_cmp && !rst) begin
      chk("R2 awready/wready", {s_awready, s_wready}, {2{!m_bvalid}});
      chk("R2 bvalid/bresp", {s_bvalid, s_bresp}, {m_bvalid, 2'b00});
      chk("R3 arready/rvalid/rresp", {s_arready, s_rvalid, s_rresp}, {!m_rvalid, m_rvalid, 2'b00});
      if (m_rvalid) chk("R3 rdata", s_rdata, m_rdata);
      chk("R4 mode", mode_o, m_mode);
      chk("R5 timing/clkdiv", {timing0_o, timing1_o, clkdiv_o}, {m_t0, m_t1, m_cdiv});
      chk("R6 code", acc_code_o, {m_code[3], m_code[2], m_code[1], m_code[0]});
      chk("R6 mask", acc_mask_o, {m_mask[3], m_mask[2], m_mask[1], m_mask[0]});
      chk("R6 frame_wr", frame_wr_o, m_fwr);
      if (m_fwr) chk("R6 frame idx/data", {frame_wr_idx_o, frame_wr_data_o}, {m_fidx, m_fdat});
      chk("R7 strobes", {cmd_tx_req_o, cmd_rx_release_o}, {m_tx, m_rel});
      chk("R10 irq", irq_o, m_irq);
    end
  end

  // strobe counters observed at the ports
  int tx_cnt = 0, rel_cnt = 0, fwr_cnt = 0;
  logic [3:0] last_fidx;
  logic [7:0] last_fdat;
  always @(negedge clk) begin
    if (!rst) begin
      if (cmd_tx_req_o) tx_cnt++;
      if (cmd_rx_release_o) rel_cnt++;
      if (frame_wr_o) begin fwr_cnt++; last_fidx = frame_wr_idx_o; last_fdat = frame_wr_data_o; end
    end
  end

  task automatic axw(input logic [7:0] a, input logic [31:0] d, input logic [3:0] st);
    @(negedge clk);
    s_awaddr = a; s_wdata = d; s_wstrb = st; s_awvalid = 1; s_wvalid = 1;
    while (!s_awready) @(negedge clk);
    @(negedge clk);
    s_awvalid = 0; s_wvalid = 0;
    @(negedge clk);
  endtask

  task automatic axr(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    s_araddr = a; s_arvalid = 1;
    while (!s_arready) @(negedge clk);
    @(negedge clk);
    s_arvalid = 0;
    d = s_rdata;
    @(negedge clk);
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    summary();
  end

  initial begin
    logic [31:0] d, held;
    repeat (5) @(negedge clk);
    rst = 0;
    run_cmp = 1;
    // R11: reset state
    chk("R11 mode after reset", mode_o, 8'h01);
    chk("R11 cfg after reset", {timing0_o, timing1_o, clkdiv_o, acc_code_o, acc_mask_o}, '0);
    chk("R11 flags after reset", {s_bvalid, s_rvalid, irq_o, cmd_tx_req_o, frame_wr_o}, '0);

    // R5/R6: configuration in reset mode
    axw(8'h18, 32'h83, 4'hF);
    axw(8'h1C, 32'h2F, 4'hF);
    axw(8'h7C, 32'h88, 4'hF);
    axw(8'h40, 32'h80, 4'hF);
    axw(8'h4C, 32'h5A, 4'hF);
    axw(8'h50, 32'h7F, 4'hF);
    axw(8'h58, 32'hFFFF_FFC3, 4'hF);
    axr(8'h18, d); chk("R5 timing0 readback", d, 32'h83);
    axr(8'h7C, d); chk("R5 clkdiv readback", d, 32'h88);
    chk("R5 clkdiv fields ext/off/div", {clkdiv_o[7], clkdiv_o[3], clkdiv_o[2:0]}, {1'b1, 1'b1, 3'd0});
    axr(8'h40, d); chk("R6 code0 readback", d, 32'h80);
    axr(8'h58, d); chk("R6 mask2 readback", d, 32'hC3);
    axr(8'h60, d); chk("R6 window tail in reset mode", d, 32'h0);
    chk("R6 code port", acc_code_o, 32'h5A00_0080);
    chk("R6 mask port", acc_mask_o, 32'h00C3_007F);

    // R7/R6: ignored in reset mode
    axw(8'h04, 32'h05, 4'hF);
    chk("R7 no strobe in reset mode", {tx_cnt[7:0], rel_cnt[7:0]}, 16'h0);
    axw(8'h64, 32'h33, 4'hF);
    chk("R6 no frame write in reset mode", fwr_cnt, 0);

    // R4: enter operating mode
    axw(8'h00, 32'h00, 4'hF);
    chk("R4 mode cleared", mode_o, 8'h00);
    axw(8'h18, 32'h11, 4'hF);
    axr(8'h18, d); chk("R5 timing0 frozen", d, 32'h83);
    axw(8'h7C, 32'h07, 4'hF);
    chk("R5 clkdiv frozen", clkdiv_o, 8'h88);

    // R6: frame window in operating mode
    axw(8'h40, 32'h11, 4'hF);
    chk("R6 frame write count", fwr_cnt, 1);
    chk("R6 frame write idx/data", {last_fidx, last_fdat}, {4'd0, 8'h11});
    chk("R6 filter untouched", acc_code_o, 32'h5A00_0080);
    axw(8'h70, 32'h9E, 4'hF);
    chk("R6 last window write", {last_fidx, last_fdat}, {4'd12, 8'h9E});
    axr(8'h40, d); chk("R6 frame byte0 read", d, 32'hA0);
    axr(8'h70, d); chk("R6 frame byte12 read", d, 32'hAC);
    axr(8'h5C, d); chk("R6 frame byte7 read", d, 32'hA7);

    // R7: command strobes
    axw(8'h04, 32'h01, 4'hF);
    chk("R7 tx request", {tx_cnt[7:0], rel_cnt[7:0]}, {8'd1, 8'd0});
    axw(8'h04, 32'h04, 4'hF);
    chk("R7 rx release", {tx_cnt[7:0], rel_cnt[7:0]}, {8'd1, 8'd1});
    axw(8'h04, 32'h05, 4'hF);
    chk("R7 both strobes", {tx_cnt[7:0], rel_cnt[7:0]}, {8'd2, 8'd2});
    axr(8'h04, d); chk("R7 command reads zero", d, 32'h0);

    // R8: status and receive count
    eng_status_i = 8'h04;
    axr(8'h08, d); chk("R8 status tx free", d, 32'h04);
    eng_status_i = 8'h0C;
    axw(8'h08, 32'hFF, 4'hF);
    axr(8'h08, d); chk("R8 status live after write", d, 32'h0C);
    eng_rx_count_i = 8'h03;
    axr(8'h74, d); chk("R8 rx count", d, 32'h03);

    // R1/R3: alignment, strobe, unmapped
    axr(8'h41, d); chk("R1 unaligned address", d, 32'hA0);
    axr(8'h14, d); chk("R3 unmapped reads zero", d, 32'h0);
    axw(8'h10, 32'h01, 4'hE);
    axr(8'h10, d); chk("R1 wstrb0 low ignored", d, 32'h0);
    axw(8'h10, 32'hFFFF_FF01, 4'h1);
    axr(8'h10, d); chk("R1 enable written", d, 32'h01);

    // R9/R10: interrupts
    @(negedge clk); eng_irq_set_i = 8'h01;
    @(negedge clk); eng_irq_set_i = 8'h00;
    chk("R10 irq raised", irq_o, 1'b1);
    axr(8'h0C, d); chk("R9 pending read", d, 32'h01);
    chk("R10 irq cleared by read", irq_o, 1'b0);
    @(negedge clk); eng_irq_set_i = 8'h02;
    @(negedge clk); eng_irq_set_i = 8'h00;
    chk("R10 disabled bit no irq", irq_o, 1'b0);
    axr(8'h0C, d); chk("R9 disabled bit pending", d, 32'h02);
    @(negedge clk); s_araddr = 8'h0C; s_arvalid = 1; eng_irq_set_i = 8'h01;
    @(negedge clk); s_arvalid = 0; eng_irq_set_i = 8'h00;
    chk("R9 read data before set", s_rdata, 32'h0);
    chk("R9 set wins over clear", irq_o, 1'b1);
    @(negedge clk);
    axr(8'h0C, d); chk("R9 pending survived", d, 32'h01);

    // R2: write response backpressure
    s_bready = 0;
    @(negedge clk); s_awaddr = 8'h10; s_wdata = 32'h01; s_wstrb = 4'hF; s_awvalid = 1; s_wvalid = 1;
    @(negedge clk); s_awvalid = 0; s_wvalid = 0;
    repeat (3) @(negedge clk);
    chk("R2 bvalid held", {s_bvalid, s_awready}, 2'b10);
    s_bready = 1;
    @(negedge clk);
    chk("R2 bvalid dropped", {s_bvalid, s_awready}, 2'b01);

    // R3: read data backpressure
    s_rready = 0;
    @(negedge clk); s_araddr = 8'h18; s_arvalid = 1;
    @(negedge clk); s_arvalid = 0; held = s_rdata;
    repeat (3) @(negedge clk);
    chk("R3 rvalid/rdata held", {s_rvalid, s_arready, s_rdata}, {1'b1, 1'b0, held});
    chk("R3 held value", held, 32'h83);
    s_rready = 1;
    @(negedge clk);
    chk("R3 rvalid dropped", s_rvalid, 1'b0);

    // R4/R5: back to reset mode reopens configuration
    axw(8'h00, 32'h01, 4'hF);
    axw(8'h1C, 32'h44, 4'hF);
    axr(8'h1C, d); chk("R5 timing1 after reentering reset", d, 32'h44);
    axr(8'h00, d); chk("R4 mode readback", d, 32'h01);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule